// File: doc/BRIEF.md
# Double-Precision Floating-Point Comparator

This block compares two IEEE-754 binary64 operands. It returns a 4-bit one-hot condition code saying whether A is less than, greater than, equal to, or unordered with B. A single `in_valid` strobe launches a compare. The code appears on `cc_out` one clock later with a one-cycle `cc_valid` pulse. The same code is also written into the condition field `stat_cc` of a small status register.

The status register also holds three flags:
- an invalid-operation flag;
- an invalid-compare flag, which only the ordered mode sets;
- a summary flag, which only the unordered mode sets.

The two modes treat NaN operands differently:
- **Ordered mode** first drops the invalid-operation bit. It then raises that bit again, together with the invalid-compare flag, when either operand is any kind of NaN.
- **Unordered mode** reacts only to signaling NaNs. Such an operand raises the invalid-operation and summary flags.

Apart from that ordered-mode overwrite, the flags are sticky. Only reset or `clr_flags` clears them. Arithmetic, rounding and trapping are left to neighbouring logic.

Top module: `fp64_compare`

## Requirements
- R1: A compare strobed by `in_valid` at a rising edge drives `cc_out` and a one-cycle `cc_valid` pulse after that edge. With no strobe, `cc_valid` is low and `cc_out` holds its last value.
- R2: The condition code is one-hot: 4'b1000 means A < B, 4'b0100 means A > B, 4'b0010 means equal, 4'b0001 means unordered.
- R3: The result is unordered (4'b0001) whenever either operand is a NaN, meaning the exponent bits [62:52] are all ones and the mantissa bits [51:0] are nonzero.
- R4: Positive zero and negative zero compare equal.
- R5: Non-NaN operands are ordered by sign and then by the magnitude bits [62:0], with the magnitude order reversed when both are negative. Infinities and subnormals follow the same rule.
- R6: Every compare copies its condition code into `stat_cc`.
- R7: An ordered compare (`in_mode`=1) sets `stat_invalid` to exactly "either operand is a NaN", replacing the previous value.
- R8: An ordered compare with a NaN operand sets the sticky `stat_inv_cmp` flag.
- R9: An unordered compare (`in_mode`=0) with a signaling NaN sets `stat_invalid` and `stat_summary`. A signaling NaN is a NaN with mantissa bit 51 at 0. A quiet NaN (bit 51 at 1) sets neither flag.
- R10: Flags hold their value while idle. `clr_flags` clears all three flags. When a clear and a compare fall in the same cycle, the compare's flag update is applied on top of the clear.
- R11: After reset, `cc_out`, `cc_valid`, `stat_cc` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Launch a compare this cycle |
| in_mode | input | 1 | 0 = unordered compare, 1 = ordered compare |
| clr_flags | input | 1 | Clear the sticky status flags |
| opnd_a | input | 64 | Operand A, binary64 |
| opnd_b | input | 64 | Operand B, binary64 |
| cc_valid | output | 1 | Result pulse, one cycle after `in_valid` |
| cc_out | output | 4 | One-hot condition code destination |
| stat_cc | output | 4 | Condition field of the status register |
| stat_invalid | output | 1 | Invalid-operation flag |
| stat_inv_cmp | output | 1 | Invalid-compare flag (ordered mode) |
| stat_summary | output | 1 | Summary flag (unordered mode) |

## Verification
The flag clear and a compare's own flag update can land on the same clock edge. That is the place where a wrong priority would lose a flag.

The bench provokes this in three ways, each time holding `clr_flags` high in the same cycle as `in_valid`:
- with an ordered NaN compare;
- with an unordered signaling-NaN compare;
- with an unordered non-NaN compare.

It then judges the flags one cycle later. The first two must show their mode's flags set despite the clear. The third must show all flags zero.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int EXP_W = 11;
    localparam int MAN_W = 52;
    localparam int FP_W  = 1 + EXP_W + MAN_W;
    localparam int MAG_W = FP_W - 1;
    localparam int CC_W  = 4;
    localparam int QBIT  = MAN_W - 1;

    typedef enum logic {
        CMP_UNORD = 1'b0,
        CMP_ORD   = 1'b1
    } cmp_mode_e;

    typedef enum logic [CC_W-1:0] {
        CC_NONE = 4'b0000,
        CC_UN   = 4'b0001,
        CC_EQ   = 4'b0010,
        CC_GT   = 4'b0100,
        CC_LT   = 4'b1000
    } cc_e;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_snan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } fp_class_t;

    typedef struct packed {
        logic invalid;
        logic inv_cmp;
        logic summary;
    } flag_t;

    function automatic fp_class_t classify(input logic [FP_W-1:0] v);
        fp_class_t  c;
        logic [EXP_W-1:0] e;
        logic [MAN_W-1:0] m;
        e         = v[FP_W-2 -: EXP_W];
        m         = v[MAN_W-1:0];
        c.sign    = v[FP_W-1];
        c.mag     = v[MAG_W-1:0];
        c.is_nan  = (&e) && (|m);
        c.is_snan = c.is_nan && !m[QBIT];
        c.is_zero = (e == '0) && (m == '0);
        return c;
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
(
    input  logic [FP_W-1:0] val,
    output fp_class_t       cls
);
    always_comb cls = classify(val);
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  fp_class_t a,
    input  fp_class_t b,
    output cc_e       cc
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a.mag < b.mag;
        mag_eq = a.mag == b.mag;
        if (a.is_nan || b.is_nan)
            cc = CC_UN;
        else if (a.is_zero && b.is_zero)
            cc = CC_EQ;
        else if (a.sign != b.sign)
            cc = a.sign ? CC_LT : CC_GT;
        else if (mag_eq)
            cc = CC_EQ;
        else if (mag_lt ^ a.sign)
            cc = CC_LT;
        else
            cc = CC_GT;
    end
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
    import fpcmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      upd,
    input  cmp_mode_e mode,
    input  logic      clr,
    input  logic      any_nan,
    input  logic      any_snan,
    input  cc_e       cc_in,
    output cc_e       cc_field,
    output flag_t     flags
);
    flag_t nxt;

    always_comb begin
        nxt = clr ? flag_t'('0) : flags;
        if (upd) begin
            if (mode == CMP_ORD) begin
                nxt.invalid = any_nan;
                if (any_nan) nxt.inv_cmp = 1'b1;
            end else if (any_snan) begin
                nxt.invalid = 1'b1;
                nxt.summary = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            cc_field <= CC_NONE;
        end else begin
            flags <= nxt;
            if (upd) cc_field <= cc_in;
        end
    end
endmodule

// File: rtl/fp64_compare.sv
module fp64_compare
    import fpcmp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_mode,
    input  logic          clr_flags,
    input  logic [63:0]   opnd_a,
    input  logic [63:0]   opnd_b,
    output logic          cc_valid,
    output logic [3:0]    cc_out,
    output logic [3:0]    stat_cc,
    output logic          stat_invalid,
    output logic          stat_inv_cmp,
    output logic          stat_summary
);
    localparam int NOPS = 2;

    logic [FP_W-1:0] opnd [NOPS];
    fp_class_t       cls  [NOPS];
    cc_e             cc_c;
    cc_e             cc_q;
    cc_e             cc_field;
    flag_t           flags;
    logic            vld_q;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        fpcmp_classify u_cls (.val(opnd[i]), .cls(cls[i]));
    end

    fpcmp_order u_order (.a(cls[0]), .b(cls[1]), .cc(cc_c));

    fpcmp_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .upd      (in_valid),
        .mode     (cmp_mode_e'(in_mode)),
        .clr      (clr_flags),
        .any_nan  (cls[0].is_nan  || cls[1].is_nan),
        .any_snan (cls[0].is_snan || cls[1].is_snan),
        .cc_in    (cc_c),
        .cc_field (cc_field),
        .flags    (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q  <= CC_NONE;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) cc_q <= cc_c;
        end
    end

    assign cc_valid     = vld_q;
    assign cc_out       = cc_q;
    assign stat_cc      = cc_field;
    assign stat_invalid = flags.invalid;
    assign stat_inv_cmp = flags.inv_cmp;
    assign stat_summary = flags.summary;
endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_mode,
    input logic        clr_flags,
    input logic [63:0] opnd_a,
    input logic [63:0] opnd_b,
    input logic        cc_valid,
    input logic [3:0]  cc_out,
    input logic [3:0]  stat_cc,
    input logic        stat_invalid,
    input logic        stat_inv_cmp,
    input logic        stat_summary
);
    logic a_nan, b_nan, any_nan, any_snan, both_zero;
    assign a_nan     = (opnd_a[62:52] == 11'h7FF) && (opnd_a[51:0] != '0);
    assign b_nan     = (opnd_b[62:52] == 11'h7FF) && (opnd_b[51:0] != '0);
    assign any_nan   = a_nan || b_nan;
    assign any_snan  = (a_nan && !opnd_a[51]) || (b_nan && !opnd_b[51]);
    assign both_zero = (opnd_a[62:0] == '0) && (opnd_b[62:0] == '0);

    assert_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> cc_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!cc_valid && $stable(cc_out)));
    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        cc_valid |-> ($countones(cc_out) == 1));
    assert_nan_unord_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && any_nan) |=> (cc_out == 4'b0001));
    assert_zero_eq_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && both_zero) |=> (cc_out == 4'b0010));
    assert_copy_R6: assert property (@(posedge clk) disable iff (rst)
        cc_valid |-> (stat_cc == cc_out));
    assert_ord_inv_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode) |=> (stat_invalid == $past(any_nan)));
    assert_ord_icmp_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode && any_nan) |=> stat_inv_cmp);
    assert_unord_snan_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mode && any_snan) |=> (stat_invalid && stat_summary));
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr_flags) |=> $stable({stat_invalid, stat_inv_cmp, stat_summary}));
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_flags && !in_valid) |=> !(stat_invalid || stat_inv_cmp || stat_summary));
endmodule

bind fp64_compare fpcmp_checker u_chk (.*);

// File: tb/fp64_compare_tb.sv
`timescale 1ns/1ps
module fp64_compare_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic        clr_flags = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        cc_valid;
    logic [3:0]  cc_out;
    logic [3:0]  stat_cc;
    logic        stat_invalid, stat_inv_cmp, stat_summary;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fp64_compare u_dut (.*);

    localparam logic [63:0] P1   = 64'h3FF0000000000000;
    localparam logic [63:0] P2   = 64'h4000000000000000;
    localparam logic [63:0] N1   = 64'hBFF0000000000000;
    localparam logic [63:0] N2   = 64'hC000000000000000;
    localparam logic [63:0] PZ   = 64'h0000000000000000;
    localparam logic [63:0] NZ   = 64'h8000000000000000;
    localparam logic [63:0] PINF = 64'h7FF0000000000000;
    localparam logic [63:0] NINF = 64'hFFF0000000000000;
    localparam logic [63:0] QNAN = 64'h7FF8000000000000;
    localparam logic [63:0] SNAN = 64'h7FF0000000000001;
    localparam logic [63:0] DEN  = 64'h0000000000000001;

    localparam int NV = 13;
    localparam logic [63:0] VA [NV] = '{P1, P2, N1, N2, PZ, N1, PINF, NINF, P1, QNAN, DEN, NZ, P1};
    localparam logic [63:0] VB [NV] = '{P2, P1, N2, N1, NZ, P1, P2,   N2,   P1, P1,   PZ,  DEN, SNAN};
    localparam logic [3:0]  VE [NV] = '{4'h8, 4'h4, 4'h4, 4'h8, 4'h2, 4'h8, 4'h4, 4'h8, 4'h2, 4'h1, 4'h4, 4'h8, 4'h1};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] a, input logic [63:0] b, input logic m, input logic c);
        @(negedge clk);
        opnd_a = a; opnd_b = b; in_mode = m; clr_flags = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; clr_flags = 1'b0;
    endtask

    task automatic clear_only();
        @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    function automatic logic [2:0] fl();
        return {stat_invalid, stat_inv_cmp, stat_summary};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset cc_out", cc_out, 0);
        chk("R11 reset flags", {stat_cc, fl(), cc_valid}, 0);
        rst = 1'b0;

        // R2 R3 R4 R5 R6: vector table, unordered mode
        for (int i = 0; i < NV; i++) begin
            run(VA[i], VB[i], 1'b0, 1'b0);
            chk($sformatf("R2/R5 vec%0d cc_out", i), cc_out, VE[i]);
            chk($sformatf("R6 vec%0d stat_cc", i), stat_cc, VE[i]);
            chk($sformatf("R1 vec%0d cc_valid", i), cc_valid, 1);
            if (i == 9) chk("R9 quiet NaN no flags", fl(), 3'b000);
        end
        chk("R9 signaling NaN flags", fl(), 3'b101);

        // R1: idle holds, no pulse; R10 sticky
        @(negedge clk);
        chk("R1 idle cc_valid", cc_valid, 0);
        chk("R1 hold cc_out", cc_out, 4'h1);
        chk("R10 flags sticky while idle", fl(), 3'b101);

        clear_only();
        chk("R10 clear", fl(), 3'b000);

        run(QNAN, P1, 1'b0, 1'b0);
        chk("R9 quiet NaN unordered cc", cc_out, 4'h1);
        chk("R9 quiet NaN leaves flags", fl(), 3'b000);

        run(P2, QNAN, 1'b1, 1'b0);
        chk("R3 ordered NaN cc", cc_out, 4'h1);
        chk("R7/R8 ordered NaN flags", fl(), 3'b110);

        run(N1, N2, 1'b1, 1'b0);
        chk("R5 ordered -1 vs -2", cc_out, 4'h4);
        chk("R7 invalid overwritten, R8 inv_cmp sticky", fl(), 3'b010);

        // same-cycle clear and compare
        run(SNAN, P1, 1'b1, 1'b1);
        chk("R10 clear+ordered NaN", fl(), 3'b110);
        run(SNAN, SNAN, 1'b0, 1'b1);
        chk("R10 clear+unordered sNaN", fl(), 3'b101);
        run(NZ, PZ, 1'b0, 1'b1);
        chk("R10 clear+plain compare", fl(), 3'b000);
        chk("R4 -0 vs +0", cc_out, 4'h2);

        run(NINF, PINF, 1'b1, 1'b0);
        chk("R5 -inf vs +inf", cc_out, 4'h8);
        chk("R7 ordered no NaN", fl(), 3'b000);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 re-reset", {cc_out, stat_cc, fl(), cc_valid}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule